// File: doc/BRIEF.md
# AHB-Lite Bridge to Asynchronous Parallel Memory

This block is an AHB-Lite slave that lets a processor reach external asynchronous devices, such as SRAM or NOR flash, over a narrow shared data bus. It claims single transfers that fall in a fixed 128 MB window. Each claimed transfer becomes one or more external cycles. The external data bus is 8 or 16 bits wide, set at build time, so a word transfer can turn into two or four external cycles.

Every external cycle runs through four fixed phases:

- an address phase, which drives the address;
- two access phases, during which the memory is read or written;
- a return phase.

HREADYOUT stays low until the return phase of the last cycle. For reads, the external bytes are gathered into their AHB lanes. For writes, per-byte enables act as the write strobes.

Two chip selects share the data and address lines, and one address bit picks between them. Misaligned transfers are split in the same way as aligned ones. A byte at any address always travels on the AHB lane given by its two lowest address bits.

Top module: `ext_mem_bridge`

## Requirements
- R1: A transfer is claimed only when hsel, hready and htrans[1] (NONSEQ or SEQ) are all high, haddr[31:27] equals 5'b01110 (window 0x7000_0000 to 0x77FF_FFFF) and hsize is at most 2. An unclaimed transfer leaves hreadyout high, both chip selects high and the memory unchanged. After reset the block is idle: hreadyout is 1, mem_cs_n is 2'b11, mem_oe_n is 1, all mem_be_n bits are 1 and mem_dq_oe is 0.
- R2: haddr[26]=0 drives mem_cs_n=2'b10 and haddr[26]=1 drives mem_cs_n=2'b01. At most one select is low, and it stays unchanged for the whole transfer.
- R3: The external data width DW is 8 or 16. mem_addr equals the device byte offset (haddr[25:0] plus the position within the transfer) divided by DW/8.
- R4: A transfer covering bytes haddr to haddr+2^hsize-1 is split into one external cycle per DW-wide external word it touches, in ascending address order.
- R5: The byte at address a travels on AHB lane a[1:0] (bits 8*a[1:0]+7 down to 8*a[1:0]) and on external lane a mod (DW/8). This holds for aligned and misaligned transfers alike.
- R6: Each external cycle lasts four clocks: address, access, access, return. hreadyout is 1 only in the return clock of the last cycle, so an N-cycle transfer adds 4N-1 wait states. hresp is always OKAY (0).
- R7: A transfer with hburst other than 3'b000 (SINGLE) is not claimed.
- R8: In a write cycle, mem_be_n[j] is low only in the second access clock, and only for external lanes holding bytes of the transfer. Every strobe is high again for the clock before mem_addr changes.
- R9: mem_oe_n is low only during the two access clocks of read cycles. Read data is sampled at the end of the second access clock. In the final return clock hrdata carries the read bytes, with lanes that were not read set to zero.
- R10: Write data is taken from hwdata in the first data-phase clock. mem_dq_oe is 1 only in the access and return clocks of write cycles.
- R11: A new transfer presented while the current one is in its final return clock is accepted at that edge. Its address clock follows with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | AHB address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write when 1 |
| hsize | input | 3 | Transfer size, log2 of bytes |
| hburst | input | 3 | Burst type |
| hwdata | input | 32 | Write data |
| hready | input | 1 | Bus ready in |
| hreadyout | output | 1 | Slave ready out |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data |
| mem_addr | output | 26-log2(DW/8) | External word address |
| mem_cs_n | output | 2 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | DW/8 | Active-low byte write strobes |
| mem_dq_o | output | DW | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DW | Data from memory |

## Verification
The final return clock of one transfer is also the clock in which the next transfer's address phase is accepted, so completion and acceptance share an edge. The bench presents every transfer pipelined behind the previous one. This includes a write followed at once by a read of the same bytes. The per-clock reference model expects the next address clock right after the return clock, and the read must return the bytes that were just written. Any lost, repeated or late acceptance shows up as a mismatch on hreadyout, the chip selects or hrdata.

// File: rtl/ext_mem_bridge.sv
module ext_mem_bridge #(
  parameter int          DW       = 16,
  parameter logic [31:0] WIN_BASE = 32'h7000_0000,
  parameter int          WIN_BITS = 27,
  parameter int          CS_BIT   = 26
) (
  input  logic                                  hclk,
  input  logic                                  hresetn,
  input  logic                                  hsel,
  input  logic [31:0]                           haddr,
  input  logic [1:0]                            htrans,
  input  logic                                  hwrite,
  input  logic [2:0]                            hsize,
  input  logic [2:0]                            hburst,
  input  logic [31:0]                           hwdata,
  input  logic                                  hready,
  output logic                                  hreadyout,
  output logic                                  hresp,
  output logic [31:0]                           hrdata,
  output logic [CS_BIT-$clog2(DW/8)-1:0]        mem_addr,
  output logic [1:0]                            mem_cs_n,
  output logic                                  mem_oe_n,
  output logic [DW/8-1:0]                       mem_be_n,
  output logic [DW-1:0]                         mem_dq_o,
  output logic                                  mem_dq_oe,
  input  logic [DW-1:0]                         mem_dq_i
);
  localparam int BW = DW / 8;
  localparam int SH = $clog2(BW);
  localparam int OW = CS_BIT;
  localparam int AW = OW - SH;

  logic          busy, wr, csel, fresh;
  logic [1:0]    ph;
  logic [OW-1:0] cur_a, start_a, end_a;
  logic [31:0]   wbuf, rbuf;
  logic [BW-1:0] lane_en;

  function automatic logic [1:0] lane_of(input logic [OW-1:0] base, input int j);
    return base[1:0] + 2'(j);
  endfunction

  wire in_win    = haddr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS];
  wire take      = hsel & hready & htrans[1] & in_win & (hburst == 3'b000) & (hsize <= 3'd2);
  wire last_beat = cur_a[OW-1:SH] == end_a[OW-1:SH];

  always_comb
    for (int j = 0; j < BW; j++)
      lane_en[j] = (cur_a + OW'(j) >= start_a) && (cur_a + OW'(j) <= end_a);

  always_comb
    for (int j = 0; j < BW; j++)
      mem_dq_o[8*j +: 8] = wbuf[8*lane_of(cur_a, j) +: 8];

  always_ff @(posedge hclk or negedge hresetn)
    if (!hresetn) begin
      busy    <= 1'b0;
      ph      <= 2'd0;
      wr      <= 1'b0;
      csel    <= 1'b0;
      fresh   <= 1'b0;
      cur_a   <= '0;
      start_a <= '0;
      end_a   <= '0;
      wbuf    <= '0;
      rbuf    <= '0;
    end else begin
      if (busy) begin
        ph <= ph + 2'd1;
        if (fresh) begin
          wbuf  <= hwdata;
          fresh <= 1'b0;
        end
        if (ph == 2'd2 && !wr)
          for (int j = 0; j < BW; j++)
            if (lane_en[j]) rbuf[8*lane_of(cur_a, j) +: 8] <= mem_dq_i[8*j +: 8];
        if (ph == 2'd3) begin
          if (last_beat) busy  <= 1'b0;
          else           cur_a <= cur_a + OW'(BW);
        end
      end
      if (take) begin
        busy    <= 1'b1;
        ph      <= 2'd0;
        wr      <= hwrite;
        fresh   <= hwrite;
        csel    <= haddr[CS_BIT];
        start_a <= haddr[OW-1:0];
        end_a   <= haddr[OW-1:0] + ((OW'(1) << hsize) - OW'(1));
        cur_a   <= haddr[OW-1:0] & ~OW'(BW - 1);
        rbuf    <= '0;
      end
    end

  assign hreadyout = !busy || (ph == 2'd3 && last_beat);
  assign hresp     = 1'b0;
  assign hrdata    = rbuf;
  assign mem_addr  = cur_a[OW-1:SH];
  assign mem_cs_n  = !busy ? 2'b11 : (csel ? 2'b01 : 2'b10);
  assign mem_oe_n  = !(busy && !wr && (ph == 2'd1 || ph == 2'd2));
  assign mem_be_n  = (busy && wr && ph == 2'd2) ? ~lane_en : {BW{1'b1}};
  assign mem_dq_oe = busy && wr && (ph != 2'd0);
endmodule

module ext_mem_bridge_chk #(
  parameter int AW = 25,
  parameter int BW = 2
) (
  input logic          hclk,
  input logic          hresetn,
  input logic          hreadyout,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_cs_n,
  input logic          mem_oe_n,
  input logic [BW-1:0] mem_be_n,
  input logic          mem_dq_oe
);
  p_cs_onehot_r2: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot0(~mem_cs_n));
  p_cs_hold_r2: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |=> $stable(mem_cs_n));
  p_wait_has_cs_r6: assert property (@(posedge hclk) disable iff (!hresetn)
    !hreadyout |-> !(&mem_cs_n));
  p_strobe_data_r8: assert property (@(posedge hclk) disable iff (!hresetn)
    !(&mem_be_n) |-> mem_dq_oe);
  p_strobe_single_r8: assert property (@(posedge hclk) disable iff (!hresetn)
    !(&mem_be_n) |=> (&mem_be_n));
  p_addr_after_release_r8: assert property (@(posedge hclk) disable iff (!hresetn)
    !$stable(mem_addr) |-> $past(&mem_be_n));
  p_oe_in_wait_r9: assert property (@(posedge hclk) disable iff (!hresetn)
    !mem_oe_n |-> !hreadyout);
  p_no_contention_r10: assert property (@(posedge hclk) disable iff (!hresetn)
    mem_dq_oe |-> mem_oe_n);
endmodule

bind ext_mem_bridge ext_mem_bridge_chk #(.AW(AW), .BW(BW)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .hreadyout(hreadyout), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/ext_mem_bridge_tb.sv
module ext_mem_bridge_tb_lane #(
  parameter int DW = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_err
);
  localparam int BW = DW / 8;
  localparam int AW = 26 - $clog2(BW);

  logic          hsel, hwrite, hreadyout, hresp, mem_oe_n, mem_dq_oe;
  logic [31:0]   haddr, hwdata, hrdata;
  logic [1:0]    htrans, mem_cs_n;
  logic [2:0]    hsize, hburst;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_be_n;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  typedef struct {
    logic          rdy;
    logic [1:0]    cs_n;
    logic          oe_n;
    logic [BW-1:0] be_n;
    logic          dqoe;
    logic          chk_addr;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq;
    logic [DW-1:0] dqm;
    logic          chk_rd;
    logic [31:0]   rd;
  } exp_t;

  exp_t        q[$];
  logic [7:0]  sram [2][64];
  logic [7:0]  gold [2][64];
  logic [31:0] nxt_wd;
  string       scen;

  ext_mem_bridge #(.DW(DW)) u_dut (
    .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hready(hreadyout), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  wire csi = mem_cs_n[0];

  always_comb
    for (int j = 0; j < BW; j++)
      mem_dq_i[8*j +: 8] = (!mem_oe_n && mem_cs_n != 2'b11)
                           ? sram[csi][(int'(mem_addr) * BW + j) % 64] : 8'hA5;

  always @(posedge clk)
    for (int j = 0; j < BW; j++)
      if (!mem_be_n[j] && mem_cs_n != 2'b11)
        sram[csi][(int'(mem_addr) * BW + j) % 64] <= mem_dq_o[8*j +: 8];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (%s) DW=%0d act=%h exp=%h", what, scen, DW, act, exp);
    end
  endtask

  function automatic exp_t idle_rec();
    exp_t e;
    e.rdy = 1'b1; e.cs_n = 2'b11; e.oe_n = 1'b1; e.be_n = '1; e.dqoe = 1'b0;
    e.chk_addr = 1'b0; e.addr = '0; e.dq = '0; e.dqm = '0; e.chk_rd = 1'b0; e.rd = '0;
    return e;
  endfunction

  task automatic build(input logic [31:0] a, input int sz, input logic w, input logic [31:0] wd);
    int          nb, off, first, last, cs;
    logic [31:0] rd;
    nb = 1 << sz; off = int'(a[25:0]); cs = int'(a[26]);
    first = off / BW; last = (off + nb - 1) / BW;
    rd = '0;
    for (int k = 0; k < nb; k++) begin
      if (w) gold[cs][(off + k) % 64] = wd[8*((off + k) % 4) +: 8];
      else   rd[8*((off + k) % 4) +: 8] = gold[cs][(off + k) % 64];
    end
    for (int wi = first; wi <= last; wi++) begin
      logic [BW-1:0] en;
      logic [DW-1:0] dq, dqm;
      for (int j = 0; j < BW; j++) begin
        int ba;
        ba = wi * BW + j;
        en[j] = (ba >= off) && (ba <= off + nb - 1);
        dqm[8*j +: 8] = en[j] ? 8'hFF : 8'h00;
        dq[8*j +: 8]  = en[j] ? wd[8*(ba % 4) +: 8] : 8'h00;
      end
      for (int p = 0; p < 4; p++) begin
        exp_t e;
        e = idle_rec();
        e.rdy      = (p == 3) && (wi == last);
        e.cs_n     = cs ? 2'b01 : 2'b10;
        e.oe_n     = !(!w && (p == 1 || p == 2));
        e.be_n     = (w && p == 2) ? ~en : '1;
        e.dqoe     = w && p != 0;
        e.chk_addr = 1'b1;
        e.addr     = AW'(wi);
        e.dq       = (w && p != 0) ? dq : '0;
        e.dqm      = (w && p != 0) ? dqm : '0;
        e.chk_rd   = !w && p == 3 && wi == last;
        e.rd       = rd;
        q.push_back(e);
      end
    end
  endtask

  task automatic issue(input logic [31:0] a, input int sz, input logic w, input logic [31:0] wd,
                       input logic sel = 1'b1, input logic [1:0] tr = 2'b10,
                       input logic [2:0] bu = 3'b000);
    @(negedge clk);
    hsel = sel; haddr = a; htrans = tr; hwrite = w; hsize = 3'(sz); hburst = bu;
    hwdata = nxt_wd;
    while (!hreadyout) @(negedge clk);
    nxt_wd = wd;
    if (sel && tr[1] && a[31:27] == 5'b01110 && bu == 3'b000 && sz <= 2) build(a, sz, w, wd);
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 64; i++) begin
        sram[c][i] = 8'((i * 7 + c * 64) ^ 8'h5A);
        gold[c][i] = 8'((i * 7 + c * 64) ^ 8'h5A);
      end
  end

  initial begin
    exp_t e;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk); #3;
      if (q.size() > 0) e = q.pop_front();
      else              e = idle_rec();
      chk("R6 hreadyout", 32'(hreadyout), 32'(e.rdy));
      chk("R6 hresp", 32'(hresp), 32'd0);
      chk("R2 mem_cs_n", 32'(mem_cs_n), 32'(e.cs_n));
      chk("R9 mem_oe_n", 32'(mem_oe_n), 32'(e.oe_n));
      chk("R8 mem_be_n", 32'(mem_be_n), 32'(e.be_n));
      chk("R10 mem_dq_oe", 32'(mem_dq_oe), 32'(e.dqoe));
      if (e.chk_addr) chk("R3 R4 mem_addr", 32'(mem_addr), 32'(e.addr));
      if (e.dqm != '0) chk("R5 mem_dq_o", 32'(mem_dq_o & e.dqm), 32'(e.dq));
      if (e.chk_rd) chk("R5 R9 hrdata", hrdata, e.rd);
    end
  end

  initial begin
    done = 1'b0; n_chk = 0; n_err = 0; nxt_wd = '0;
    hsel = 0; haddr = '0; htrans = 2'b00; hwrite = 0; hsize = '0; hburst = '0; hwdata = '0;
    scen = "R1 reset";
    @(posedge clk); #3;
    chk("R1 reset hreadyout", 32'(hreadyout), 32'd1);
    chk("R1 reset mem_cs_n", 32'(mem_cs_n), 32'h3);
    chk("R1 reset mem_be_n", 32'(mem_be_n), 32'((1 << BW) - 1));
    chk("R1 reset mem_dq_oe", 32'(mem_dq_oe), 32'd0);
    wait (rst_n === 1'b1);
    repeat (2) @(negedge clk);
    scen = "R4 word write";      issue(32'h7000_0000, 2, 1, 32'h1122_3344);
    scen = "R5 half write";      issue(32'h7000_0006, 1, 1, 32'hAABB_CCDD);
    scen = "R5 byte writes";     issue(32'h7000_0009, 0, 1, 32'h0000_7700);
                                 issue(32'h7000_000B, 0, 1, 32'h9900_0000);
    scen = "R2 second device";   issue(32'h7400_0010, 2, 1, 32'hCAFE_F00D);
                                 issue(32'h7400_0010, 2, 0, 32'h0);
    scen = "R5 byte reads";
    for (int a = 0; a < 4; a++)  issue(32'h7000_0000 + 32'(a), 0, 0, 32'h0);
    scen = "R4 half reads";      issue(32'h7000_0000, 1, 0, 32'h0);
                                 issue(32'h7000_0006, 1, 0, 32'h0);
    scen = "R4 word reads";      issue(32'h7000_0004, 2, 0, 32'h0);
                                 issue(32'h7000_0008, 2, 0, 32'h0);
    issue(32'h0, 0, 0, 32'h0, 1'b0, 2'b00);
    scen = "R5 misaligned";      issue(32'h7000_0001, 1, 0, 32'h0);
                                 issue(32'h7000_0002, 2, 0, 32'h0);
                                 issue(32'h7000_000B, 2, 1, 32'h0102_0304);
                                 issue(32'h7000_000B, 2, 0, 32'h0);
                                 issue(32'h7000_0015, 1, 1, 32'hE1E2_E3E4);
                                 issue(32'h7000_0014, 2, 0, 32'h0);
    scen = "R11 back to back";   issue(32'h7000_0021, 0, 1, 32'h0000_5A00);
                                 issue(32'h7000_0020, 2, 0, 32'h0);
    scen = "R1 out of window";   issue(32'h7800_0000, 2, 1, 32'hBAD0_0001);
                                 issue(32'h6FFF_FFFC, 2, 1, 32'hBAD0_0002);
    scen = "R1 not selected";    issue(32'h7000_0000, 2, 1, 32'hBAD0_0003, 1'b0);
    scen = "R1 idle trans";      issue(32'h7000_0000, 2, 1, 32'hBAD0_0004, 1'b1, 2'b00);
    scen = "R7 burst";           issue(32'h7000_0000, 2, 1, 32'hBAD0_0005, 1'b1, 2'b10, 3'b011);
    scen = "R7 R1 readback";     issue(32'h7000_0000, 2, 0, 32'h0);
                                 issue(32'h7000_003C, 2, 0, 32'h0);
    scen = "R1 drain";           issue(32'h0, 0, 0, 32'h0, 1'b0, 2'b00);
    repeat (8) @(negedge clk);
    done = 1'b1;
  end
endmodule

module ext_mem_bridge_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d16, d8;
  int   c16, e16, c8, e8;

  always #5 clk = ~clk;

  ext_mem_bridge_tb_lane #(.DW(16)) u_w16 (.clk(clk), .rst_n(rst_n), .done(d16), .n_chk(c16), .n_err(e16));
  ext_mem_bridge_tb_lane #(.DW(8))  u_w8  (.clk(clk), .rst_n(rst_n), .done(d8),  .n_chk(c8),  .n_err(e8));

  initial begin
    int cyc, chks, errs;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc = 0;
    while (!(d16 === 1'b1 && d8 === 1'b1) && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    chks = c16 + c8 + 1;
    errs = e16 + e8;
    if (!(d16 === 1'b1 && d8 === 1'b1)) begin
      errs++;
      $display("FAIL R6 watchdog expired act=%0d exp=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", chks, errs);
    $finish;
  end
endmodule